// File: doc/BRIEF.md
# Skip-Sample Shifted Word Fetcher

This block reads one 64-bit processor word per site group of a lattice bit-field and returns it already shifted. The bit-field occupies a sector of S = 64·G sites held as G words. Word w, bit j holds site w + j·G, so each word carries 64 sites spread evenly across the sector. A uniform periodic shift of the whole field then needs no data movement. It becomes a different word address plus a barrel rotation of the word that comes back. Sites pushed past the end of the sector wrap to its start.

The shift amount has two fields. The low six bits r pick the rotation and the high bits a offset the word address modulo G, so the lattice displacement is d = r·G + a. Output bit j of site group g takes site (g + j·G + d) mod S. The block drives row, column and 4:1 sub-word addresses to a memory of 2K rows by 8 columns of 256-bit words. It takes the returned 256-bit word in the same cycle, selects the 64-bit slice and rotates it. A wrap mask marks the lanes whose source site wrapped, for a downstream substitution stage.

There are two ways to issue accesses. A single request fetches the word for one given site group. A start strobe sweeps all G groups. The sweep visits word addresses 0, 1, …, G-1 in order, so all 32 words of a row are consumed before the row changes, and it reports with each beat the site group that the word belongs to.

Top module: `skip_fetch`

## Requirements
- R1: While rst_ni is low, and in the first cycle after reset, valid_o and busy_o are 0.
- R2: When busy_o is 0, req_i is 1 and start_i is 0, the next cycle shows valid_o=1 and group_o=group_i, and the word address w=(g+a) mod G is split as sub_o=w[1:0], col_o=w[4:2], row_o=w>>5. Here shift_i[5:0]=r and shift_i[13:6]=a.
- R3: rot_o = (r + c) mod 64, where the carry c is 1 when g + a ≥ G.
- R4: The sub-word slice is rdata_i[64·sub_o +: 64]. data_o bit j equals site (g + j·G + r·G + a) mod S, where the memory model puts site w + j·G of the field at bit j of word w. With rot_o=0, data_o is the unrotated slice.
- R5: wrap_o bit j is 1 exactly when g + j·G + d ≥ S. For r=63 with carry, wrap_o is all ones while rot_o is 0.
- R6: A start_i while busy_o is 0 latches shift_i. It gives G beats with valid_o=1 in consecutive cycles, starting the next cycle. Beat k carries word address k and group_o=(k−a) mod G. busy_o is 1 on beats 0 to G−2 and 0 on the last beat.
- R7: While busy_o is 1, start_i, req_i, group_i and shift_i have no effect on the beats of the sweep in progress.
- R8: When start_i and req_i are both 1 while idle, the sweep starts and the single request is dropped.
- R9: When busy_o is 0 and neither start_i nor req_i is 1, valid_o is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a sweep over all site groups |
| req_i | input | 1 | Single fetch for group_i |
| group_i | input | GRP_W (8) | Site group of a single fetch |
| shift_i | input | GRP_W+6 (14) | Shift: [5:0] rotation part, upper bits word offset |
| rdata_i | input | DW (256) | Memory word returned for row_o/col_o |
| valid_o | output | 1 | Beat valid |
| busy_o | output | 1 | Sweep in progress, more beats pending |
| group_o | output | GRP_W (8) | Site group of the beat |
| row_o | output | ROW_W (11) | Memory row address |
| col_o | output | COL_W (3) | Column of the 256-bit word |
| sub_o | output | 2 | 64-bit slice select |
| rot_o | output | 6 | Rotation applied to the slice |
| wrap_o | output | 64 | Lanes whose source site wrapped |
| data_o | output | 64 | Shifted processor word |

## Verification
The assertions assume that rdata_i holds, within the cycle, the memory word addressed by row_o and col_o. The bench's memory model is combinational for that reason. They also assume that no request is accepted during a sweep except through the sequencer's own priority. The stimulus drives inputs only at falling edges and draws groups and shift amounts from $urandom over their full ranges. It also aims directed cases at the carry corner, where r=63 rotates by zero while every lane wraps. During one sweep it changes every input mid-sweep to show that the beats do not follow.

// File: rtl/skip_fetch_pkg.sv
package skip_fetch_pkg;
  localparam int unsigned LANES  = 64;
  localparam int unsigned ROT_W  = 6;
  typedef logic [LANES-1:0] lane_t;
endpackage

// File: rtl/skip_fetch_seq.sv
module skip_fetch_seq
  import skip_fetch_pkg::*;
#(
  parameter int unsigned GRP_W = 8,
  localparam int unsigned SH_W = GRP_W + ROT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             req_i,
  input  logic [GRP_W-1:0] group_i,
  input  logic [SH_W-1:0]  shift_i,
  output logic             iss_v_o,
  output logic             iss_swp_o,
  output logic [GRP_W-1:0] iss_grp_o,
  output logic [SH_W-1:0]  iss_sh_o,
  output logic             busy_o
);
  logic             busy_q;
  logic [GRP_W-1:0] cnt_q;
  logic [SH_W-1:0]  sh_q;
  logic [GRP_W-1:0] off_i, off_q;

  assign off_i = shift_i[SH_W-1:ROT_W];
  assign off_q = sh_q[SH_W-1:ROT_W];

  // group index chosen so the target word equals the sweep counter
  always_comb begin
    iss_v_o   = 1'b0;
    iss_swp_o = 1'b0;
    iss_grp_o = group_i;
    iss_sh_o  = shift_i;
    if (busy_q) begin
      iss_v_o   = 1'b1;
      iss_swp_o = 1'b1;
      iss_sh_o  = sh_q;
      iss_grp_o = cnt_q - off_q;
    end else if (start_i) begin
      iss_v_o   = 1'b1;
      iss_swp_o = 1'b1;
      iss_grp_o = '0 - off_i;
    end else if (req_i) begin
      iss_v_o   = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '0;
    end else if (busy_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (&cnt_q) busy_q <= 1'b0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= GRP_W'(1);
      sh_q   <= shift_i;
    end
  end

  assign busy_o = busy_q;

  AST_BUSY_HOLDS_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q)) |-> $stable(sh_q)); // R7
endmodule

// File: rtl/skip_fetch_addr.sv
module skip_fetch_addr
  import skip_fetch_pkg::*;
#(
  parameter int unsigned GRP_W = 8,
  parameter int unsigned ROW_W = 11,
  parameter int unsigned COL_W = 3,
  parameter int unsigned SUB_W = 2,
  localparam int unsigned SH_W = GRP_W + ROT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             iss_v_i,
  input  logic             iss_swp_i,
  input  logic [GRP_W-1:0] iss_grp_i,
  input  logic [SH_W-1:0]  iss_sh_i,
  output logic             valid_o,
  output logic [GRP_W-1:0] group_o,
  output logic [ROW_W-1:0] row_o,
  output logic [COL_W-1:0] col_o,
  output logic [SUB_W-1:0] sub_o,
  output logic [ROT_W-1:0] rot_o,
  output lane_t            wrap_o
);
  logic [GRP_W:0]   sum;
  logic [ROT_W:0]   k_ext;
  lane_t            wrap_d;
  logic             valid_q, swp_q;
  logic [GRP_W-1:0] grp_q, word_q;
  logic [ROT_W-1:0] rot_q;
  lane_t            wrap_q;

  assign sum   = {1'b0, iss_grp_i} + {1'b0, iss_sh_i[SH_W-1:ROT_W]};
  // rotation plus carry, 0..64; 64 means all lanes wrapped, rotate by 0
  assign k_ext = {1'b0, iss_sh_i[ROT_W-1:0]} + (ROT_W+1)'(sum[GRP_W]);

  for (genvar j = 0; j < LANES; j++) begin : g_wrap
    assign wrap_d[j] = (k_ext + (ROT_W+1)'(j)) >= (ROT_W+1)'(LANES);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      swp_q   <= 1'b0;
      grp_q   <= '0;
      word_q  <= '0;
      rot_q   <= '0;
      wrap_q  <= '0;
    end else begin
      valid_q <= iss_v_i;
      swp_q   <= iss_v_i & iss_swp_i;
      if (iss_v_i) begin
        grp_q  <= iss_grp_i;
        word_q <= sum[GRP_W-1:0];
        rot_q  <= k_ext[ROT_W-1:0];
        wrap_q <= wrap_d;
      end
    end
  end

  assign valid_o = valid_q;
  assign group_o = grp_q;
  assign sub_o   = word_q[SUB_W-1:0];
  assign col_o   = word_q[SUB_W+COL_W-1:SUB_W];
  assign row_o   = ROW_W'(word_q[GRP_W-1:SUB_W+COL_W]);
  assign rot_o   = rot_q;
  assign wrap_o  = wrap_q;

  AST_SWEEP_WORD_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (swp_q && $past(swp_q)) |-> word_q == $past(word_q) + 1'b1); // R6
  AST_WRAP_TAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && rot_q != 0) |-> wrap_q == ~({LANES{1'b1}} >> rot_q)); // R5
  AST_WRAP_EXTREME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && rot_q == 0) |-> (wrap_q == '0 || &wrap_q)); // R5
endmodule

// File: rtl/skip_fetch_rot.sv
module skip_fetch_rot
  import skip_fetch_pkg::*;
#(
  parameter int unsigned DW    = 256,
  localparam int unsigned SUB_W = $clog2(DW / LANES)
) (
  input  logic [DW-1:0]    rdata_i,
  input  logic [SUB_W-1:0] sub_i,
  input  logic [ROT_W-1:0] rot_i,
  output lane_t            data_o
);
  lane_t slice;
  lane_t stage [ROT_W+1];

  assign slice    = rdata_i[sub_i*LANES +: LANES];
  assign stage[0] = slice;

  // log-depth rotate right: out[j] = in[(j + rot) mod 64]
  for (genvar s = 0; s < ROT_W; s++) begin : g_stage
    localparam int unsigned D = 1 << s;
    assign stage[s+1] = rot_i[s] ? {stage[s][D-1:0], stage[s][LANES-1:D]} : stage[s];
  end

  assign data_o = stage[ROT_W];

  always_comb begin
    if (rot_i == '0) AST_ROT_ZERO_PASS: assert (data_o == slice); // R4
  end
endmodule

// File: rtl/skip_fetch.sv
module skip_fetch
  import skip_fetch_pkg::*;
#(
  parameter int unsigned GRP_W = 8,
  parameter int unsigned ROW_W = 11,
  parameter int unsigned COL_W = 3,
  parameter int unsigned DW    = 256,
  localparam int unsigned SUB_W = $clog2(DW / LANES),
  localparam int unsigned SH_W  = GRP_W + ROT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             req_i,
  input  logic [GRP_W-1:0] group_i,
  input  logic [SH_W-1:0]  shift_i,
  input  logic [DW-1:0]    rdata_i,
  output logic             valid_o,
  output logic             busy_o,
  output logic [GRP_W-1:0] group_o,
  output logic [ROW_W-1:0] row_o,
  output logic [COL_W-1:0] col_o,
  output logic [SUB_W-1:0] sub_o,
  output logic [ROT_W-1:0] rot_o,
  output logic [LANES-1:0] wrap_o,
  output logic [LANES-1:0] data_o
);
  logic             iss_v, iss_swp;
  logic [GRP_W-1:0] iss_grp;
  logic [SH_W-1:0]  iss_sh;

  skip_fetch_seq #(.GRP_W(GRP_W)) u_seq (
    .clk_i, .rst_ni, .start_i, .req_i, .group_i, .shift_i,
    .iss_v_o(iss_v), .iss_swp_o(iss_swp), .iss_grp_o(iss_grp),
    .iss_sh_o(iss_sh), .busy_o
  );

  skip_fetch_addr #(.GRP_W(GRP_W), .ROW_W(ROW_W), .COL_W(COL_W), .SUB_W(SUB_W)) u_addr (
    .clk_i, .rst_ni, .iss_v_i(iss_v), .iss_swp_i(iss_swp), .iss_grp_i(iss_grp),
    .iss_sh_i(iss_sh), .valid_o, .group_o, .row_o, .col_o, .sub_o, .rot_o, .wrap_o
  );

  skip_fetch_rot #(.DW(DW)) u_rot (
    .rdata_i, .sub_i(sub_o), .rot_i(rot_o), .data_o
  );

  AST_START_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> valid_o); // R6
  AST_SWEEP_CONTINUES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> valid_o); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i && !req_i) |=> !valid_o); // R9
endmodule

// File: tb/skip_fetch_test.sv
module skip_fetch_test;
  localparam int GRP_W = 8;
  localparam int G     = 1 << GRP_W;
  localparam int S     = 64 * G;
  localparam int SH_W  = GRP_W + 6;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0, req = 1'b0;
  logic [GRP_W-1:0] grp = '0;
  logic [SH_W-1:0]  sh = '0;
  logic [255:0]     rdata;
  logic             valid, busy;
  logic [GRP_W-1:0] grp_o;
  logic [10:0]      row;
  logic [2:0]       col;
  logic [1:0]       sub;
  logic [5:0]       rot;
  logic [63:0]      wrap, data;
  logic [S-1:0]     field;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  skip_fetch #(.GRP_W(GRP_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .req_i(req), .group_i(grp),
    .shift_i(sh), .rdata_i(rdata), .valid_o(valid), .busy_o(busy), .group_o(grp_o),
    .row_o(row), .col_o(col), .sub_o(sub), .rot_o(rot), .wrap_o(wrap), .data_o(data)
  );

  // memory model: word w bit j holds site w + j*G
  always_comb begin
    rdata = '0;
    for (int q = 0; q < 4; q++)
      for (int j = 0; j < 64; j++)
        if (row < 11'(G / 32))
          rdata[q*64+j] = field[int'(row)*32 + int'(col)*4 + q + j*G];
  end

  task automatic chk(bit ok, string tag, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_beat(string tag, int g, int s);
    int a = s >> 6, r = s & 63;
    int w = (g + a) % G;
    int c = (g + a) >= G;
    int er = (r + c) % 64;
    logic [63:0] ed, em;
    for (int j = 0; j < 64; j++) begin
      int idx = g + j*G + r*G + a;
      em[j] = idx >= S;
      ed[j] = field[idx % S];
    end
    total++;
    if (!(valid && grp_o == g && row == 11'(w >> 5) && col == 3'((w >> 2) & 7) &&
          sub == 2'(w & 3) && rot == 6'(er) && wrap == em && data == ed)) begin
      bad++;
      $display("FAIL %s: actual v=%0b g=%0d r/c/s=%0d/%0d/%0d rot=%0d wrap=%h data=%h expected v=1 g=%0d r/c/s=%0d/%0d/%0d rot=%0d wrap=%h data=%h",
               tag, valid, grp_o, row, col, sub, rot, wrap, data,
               g, w >> 5, (w >> 2) & 7, w & 3, er, em, ed);
    end
  endtask

  task automatic single(string tag, int g, int s);
    @(negedge clk);
    req = 1'b1; grp = GRP_W'(g); sh = SH_W'(s);
    @(negedge clk);
    req = 1'b0;
    check_beat(tag, g, s);
  endtask

  task automatic sweep(string tag, int s, bit both, bit interfere);
    int a = (s >> 6) % G;
    @(negedge clk);
    start = 1'b1; sh = SH_W'(s); req = both; grp = GRP_W'(17);
    @(negedge clk);
    start = 1'b0; req = 1'b0;
    for (int k = 0; k < G; k++) begin
      check_beat(tag, (k - a + G) % G, s);
      chk(busy == (k < G - 1), {tag, " R6 busy"}, busy, k < G - 1);
      if (interfere && k == 5) begin
        start = 1'b1; req = 1'b1; grp = GRP_W'($urandom); sh = SH_W'($urandom);
      end
      @(negedge clk);
      start = 1'b0; req = 1'b0;
    end
    chk(!valid, {tag, " R9 after sweep"}, valid, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < S; i++) field[i] = 1'($urandom);
    #1;
    chk(!valid && !busy, "R1 in reset", {valid, busy}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!valid && !busy, "R1 after reset", {valid, busy}, 0);
    // directed
    single("R2 R4 identity shift", 0, 0);
    single("R3 R4 rotate only", 9, 5);
    single("R2 R3 word offset with carry", G - 1, (1 << 6) | 0);
    single("R5 r=63 carry all lanes wrap", 200, (100 << 6) | 63);
    single("R5 r=63 no carry", 3, (4 << 6) | 63);
    single("R2 sub/col/row split", 37, (0 << 6) | 1);
    @(negedge clk);
    chk(!valid, "R9 idle", valid, 0);
    // random singles
    for (int i = 0; i < 200; i++)
      single("R2 R3 R4 R5 random", int'($urandom % G), int'($urandom % (1 << SH_W)));
    sweep("R6 sweep", (77 << 6) | 13, 1'b0, 1'b0);
    sweep("R7 sweep with interference", (3 << 6) | 63, 1'b0, 1'b1);
    sweep("R8 start beats request", (250 << 6) | 40, 1'b1, 1'b0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule